// File: doc/BRIEF.md
# Six-Step Commutation Sequencer with Gate-Drive Logic

This block turns a commutation clock into the six gate enables of a three-phase brushless motor bridge. Each rising edge of the commutation clock, once synchronised into the system clock domain, moves a three-bit step register one position forward or backward through a fixed six-entry trapezoidal table. A direction input picks the order. Each table entry enables one high-side switch and one low-side switch on a different phase.

Several inputs override the table, in a fixed priority. An undervoltage flag has the highest priority: it disables every switch and pulls an active-low fault output. A brake request comes next: it turns every high side off and every low side on. In normal running, the PWM gate and a current-limit trip act on the low sides only. A trip starts a fixed off-time, and a new trip during that off-time restarts it.

Every switch passes through a per-phase dead-time stage before it reaches an output. Turning a switch off takes effect at once. Turning a switch on has to wait until its phase has been fully off for a programmable number of cycles. As a result, the two switches of one phase never conduct together.

Top module: `bldc_commutator`

## Requirements
- R1: While `rst_n` is low (synchronous), `hs_n` is 3'b111, `ls` is 3'b000 and `fault_n` is 0. After release with `supply_low` low, `fault_n` goes to 1 and the sequencer starts in step 0.
- R2: Bit 0 of `hs_n`/`ls` is phase A, bit 1 is phase B and bit 2 is phase C. Steps 0..5 enable these high/low pairs: A/B, A/C, B/C, B/A, C/A, C/B. With no override active, `hs_n` is low for exactly the high phase and `ls` is high for exactly the low phase.
- R3: Each rising edge of `comm_clk` advances the step by one, with wrap-around. The step goes up when `dir_rev` is 0 and down when it is 1. The update lands three `clk` edges after the rising edge is first sampled. Between edges the step does not change.
- R4: A change of `dir_rev` is applied at the next commutation edge, and the step then moves from its current value in the opposite order.
- R5: When `pwm_gate` is low, all low sides are off. The high sides still follow the step.
- R6: A `ilim_trip` sample forces all low sides off for OFF_CYCLES clock cycles. The high sides are unaffected.
- R7: A trip that arrives while the off-time is running reloads the off-time to its full length.
- R8: When `brake_n` is low and supply is good, all high sides are off and all low sides are on. `pwm_gate` is ignored during braking, but a running trip off-time still holds the low sides off.
- R9: When `supply_low` is high, `fault_n` falls one cycle later and all six switches are off one cycle after that. The step register keeps following `comm_clk`.
- R10: The high-side and low-side switch of the same phase are never on in the same cycle.
- R11: After either switch of a phase turns off, both switches of that phase stay off for at least DEAD_CYCLES+1 cycles before either switch turns on again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| comm_clk | input | 1 | Commutation clock; a rising edge advances one step |
| dir_rev | input | 1 | 0 steps forward, 1 steps in reverse |
| pwm_gate | input | 1 | PWM chop for low sides, high means conduct |
| ilim_trip | input | 1 | Current-limit trip, high starts or restarts the off-time |
| brake_n | input | 1 | Active-low brake request |
| supply_low | input | 1 | Undervoltage flag, high disables all switches |
| hs_n | output | 3 | Active-low high-side enables, bit 0 = phase A |
| ls | output | 3 | Active-high low-side enables, bit 0 = phase A |
| fault_n | output | 1 | Active-low undervoltage / not-ready flag |

## Verification
The hardest case to reach from the ports is a second trip that lands inside a running off-time. It is only visible as the low sides staying off past the point where the first trip would have released them. Directed stimulus spaces two single-cycle trips ten cycles apart and samples after the first window would have closed.

Dead-time gaps are also hard to see, because they only appear when the same phase hands over from one switch to the other. Random brake, PWM and undervoltage toggles between commutation steps create many such hand-overs. A bench monitor measures each off-gap per phase.

// File: rtl/bldc_pkg.sv
// Shared types and the commutation table for the six-step sequencer.
// Assumes phase A is bit 0, phase B bit 1 and phase C bit 2 of every vector.
package bldc_pkg;

    localparam int NUM_PHASES = 3;
    localparam int NUM_STEPS  = 6;

    typedef logic [2:0] step_t;
    typedef logic [NUM_PHASES-1:0] phase_vec_t;

    // One-hot phase whose high-side switch conducts in a given step.
    function automatic phase_vec_t high_of(step_t s);
        case (s)
            3'd0, 3'd1: high_of = 3'b001;
            3'd2, 3'd3: high_of = 3'b010;
            3'd4, 3'd5: high_of = 3'b100;
            default:    high_of = 3'b000;
        endcase
    endfunction

    // One-hot phase whose low-side switch conducts in a given step.
    function automatic phase_vec_t low_of(step_t s);
        case (s)
            3'd0, 3'd5: low_of = 3'b010;
            3'd1, 3'd2: low_of = 3'b100;
            3'd3, 3'd4: low_of = 3'b001;
            default:    low_of = 3'b000;
        endcase
    endfunction

    // Neighbouring step in the chosen direction, wrapping modulo six.
    function automatic step_t step_after(step_t s, logic rev);
        if (rev) begin
            step_after = (s == 3'd0) ? step_t'(NUM_STEPS - 1) : s - 3'd1;
        end else begin
            step_after = (s == step_t'(NUM_STEPS - 1)) ? 3'd0 : s + 3'd1;
        end
    endfunction

endpackage

// File: rtl/bldc_step_seq.sv
// Synchronises the commutation clock, finds its rising edges and keeps the
// six-step position register. Assumes comm_clk pulses stay high and low for
// at least one clk period each.
module bldc_step_seq
    import bldc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  comm_clk,
    input  logic  dir_rev,
    output step_t step,
    output logic  step_pulse
);

    // Synchroniser chain; the extra top bit holds the previous synced value.
    logic [SYNC_STAGES:0] sync_q;

    // Shift the raw commutation clock through the synchroniser.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-1:0], comm_clk};
        end
    end

    assign step_pulse = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

    // Advance the step register by one position on every detected edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step <= '0;
        end else if (step_pulse) begin
            step <= step_after(step, dir_rev);
        end
    end

    // R2
    step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step < 3'd6);

    // R3
    fwd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_pulse && !dir_rev) |=>
            step == (($past(step) == 3'd5) ? 3'd0 : $past(step) + 3'd1));

    // R4
    rev_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_pulse && dir_rev) |=>
            step == (($past(step) == 3'd0) ? 3'd5 : $past(step) - 3'd1));

    // R3
    hold_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_pulse |=> $stable(step));

endmodule

// File: rtl/bldc_offtime.sv
// Constant off-time one-shot for the current-limit trip. Any cycle with the
// trip high reloads the full interval, so a trip during the interval restarts it.
module bldc_offtime #(
    parameter int OFF_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trip,
    output logic active
);

    localparam int CW = $clog2(OFF_CYCLES + 1);

    logic [CW-1:0] remain;

    // Load on trip, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (trip) begin
            remain <= CW'(OFF_CYCLES);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign active = (remain != '0);

    // R6
    trip_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> active);

    // R7
    trip_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> remain == CW'(OFF_CYCLES));

endmodule

// File: rtl/bldc_gate_req.sv
// Combines the step table with the overrides into raw switch requests.
// Priority: supply not ready, then brake, then PWM chop and trip off-time.
// The outputs are requests only; dead time is added downstream.
module bldc_gate_req
    import bldc_pkg::*;
(
    input  step_t      step,
    input  logic       drive_ok,
    input  logic       brake_n,
    input  logic       pwm_gate,
    input  logic       off_active,
    output phase_vec_t hi_req,
    output phase_vec_t lo_req
);

    phase_vec_t hi_tab;
    phase_vec_t lo_tab;

    assign hi_tab = high_of(step);
    assign lo_tab = low_of(step);

    // Pick requests according to the override priority.
    always_comb begin
        if (!drive_ok) begin
            hi_req = '0;
            lo_req = '0;
        end else if (!brake_n) begin
            hi_req = '0;
            lo_req = off_active ? '0 : '1;
        end else begin
            hi_req = hi_tab;
            lo_req = (pwm_gate && !off_active) ? lo_tab : '0;
        end
    end

    // Guard the request pattern itself before dead time is applied.
    always_comb begin
        // R10
        req_excl_chk: assert ((hi_req & lo_req) == '0);
        // R2
        hi_single_chk: assert ($onehot0(hi_req));
    end

endmodule

// File: rtl/bldc_deadtime.sv
// Dead-time stage for one phase leg. A switch that loses its request turns off
// on the next edge and loads the guard counter. No switch of the leg may turn
// on until that counter has run out. Assumes DEAD_CYCLES >= 1.
module bldc_deadtime #(
    parameter int DEAD_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hi_req,
    input  logic lo_req,
    output logic hi_on,
    output logic lo_on
);

    localparam int DW  = $clog2(DEAD_CYCLES + 1);
    localparam int IW  = $clog2(DEAD_CYCLES + 2);
    localparam int GAP = DEAD_CYCLES + 1;

    logic [DW-1:0] guard;

    // Immediate turn-off, guarded turn-on of the two switches of this leg.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_on <= 1'b0;
            lo_on <= 1'b0;
            guard <= '0;
        end else if (hi_on && !hi_req) begin
            hi_on <= 1'b0;
            guard <= DW'(DEAD_CYCLES);
        end else if (lo_on && !lo_req) begin
            lo_on <= 1'b0;
            guard <= DW'(DEAD_CYCLES);
        end else if (guard != '0) begin
            guard <= guard - 1'b1;
        end else begin
            hi_on <= hi_req && !lo_req && !lo_on;
            lo_on <= lo_req && !hi_req && !hi_on;
        end
    end

    // Checker state: cycles the leg has been fully off, saturating.
    logic [IW-1:0] idle_run;

    // Count fully-off cycles of the leg for the gap check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_run <= IW'(GAP);
        end else if (hi_on || lo_on) begin
            idle_run <= '0;
        end else if (idle_run != IW'(GAP)) begin
            idle_run <= idle_run + 1'b1;
        end
    end

    // R10
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_on && lo_on));

    // R11
    hi_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_on) |-> idle_run == IW'(GAP));

    // R11
    lo_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_on) |-> idle_run == IW'(GAP));

endmodule

// File: rtl/bldc_commutator.sv
// Top of the six-step commutation and gate-drive block. It registers the
// supply-good flag, runs the sequencer, the trip off-time and the request
// logic, and passes every leg through its own dead-time stage.
module bldc_commutator
    import bldc_pkg::*;
#(
    parameter int DEAD_CYCLES = 4,
    parameter int OFF_CYCLES  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       comm_clk,
    input  logic       dir_rev,
    input  logic       pwm_gate,
    input  logic       ilim_trip,
    input  logic       brake_n,
    input  logic       supply_low,
    output logic [2:0] hs_n,
    output logic [2:0] ls,
    output logic       fault_n
);

    logic       drive_ok;
    step_t      step;
    logic       step_pulse;
    logic       off_active;
    phase_vec_t hi_req;
    phase_vec_t lo_req;
    phase_vec_t hi_on;
    phase_vec_t lo_on;

    // Register the supply condition; held not-ready through reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drive_ok <= 1'b0;
        end else begin
            drive_ok <= !supply_low;
        end
    end

    assign fault_n = drive_ok;

    bldc_step_seq #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .comm_clk   (comm_clk),
        .dir_rev    (dir_rev),
        .step       (step),
        .step_pulse (step_pulse)
    );

    bldc_offtime #(
        .OFF_CYCLES (OFF_CYCLES)
    ) u_off (
        .clk    (clk),
        .rst_n  (rst_n),
        .trip   (ilim_trip),
        .active (off_active)
    );

    bldc_gate_req u_req (
        .step       (step),
        .drive_ok   (drive_ok),
        .brake_n    (brake_n),
        .pwm_gate   (pwm_gate),
        .off_active (off_active),
        .hi_req     (hi_req),
        .lo_req     (lo_req)
    );

    for (genvar p = 0; p < NUM_PHASES; p++) begin : g_leg
        bldc_deadtime #(
            .DEAD_CYCLES (DEAD_CYCLES)
        ) u_dt (
            .clk    (clk),
            .rst_n  (rst_n),
            .hi_req (hi_req[p]),
            .lo_req (lo_req[p]),
            .hi_on  (hi_on[p]),
            .lo_on  (lo_on[p])
        );
    end

    assign hs_n = ~hi_on;
    assign ls   = lo_on;

    // R9
    uv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_n |=> (hs_n == 3'b111 && ls == 3'b000));

    // R8
    brake_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!brake_n && fault_n) |=> hs_n == 3'b111);

    // R5
    pwm_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_gate && brake_n) |=> ls == 3'b000);

endmodule

// File: tb/bldc_commutator_tb.sv
// Self-checking bench: directed reset, stepping, trip and retrigger cases
// plus seeded random override mixes between commutation steps.
module bldc_commutator_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DEAD = 4;
    localparam int OFF  = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       comm_clk = 1'b0;
    logic       dir_rev = 1'b0;
    logic       pwm_gate = 1'b1;
    logic       ilim_trip = 1'b0;
    logic       brake_n = 1'b1;
    logic       supply_low = 1'b0;
    logic [2:0] hs_n;
    logic [2:0] ls;
    logic       fault_n;

    int checks = 0;
    int errors = 0;
    int exp_step = 0;
    int overlaps = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bldc_commutator #(
        .DEAD_CYCLES (DEAD),
        .OFF_CYCLES  (OFF),
        .SYNC_STAGES (2)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .comm_clk   (comm_clk),
        .dir_rev    (dir_rev),
        .pwm_gate   (pwm_gate),
        .ilim_trip  (ilim_trip),
        .brake_n    (brake_n),
        .supply_low (supply_low),
        .hs_n       (hs_n),
        .ls         (ls),
        .fault_n    (fault_n)
    );

    function automatic logic [2:0] tab_hi(int s);
        case (s)
            0, 1:    return 3'b001;
            2, 3:    return 3'b010;
            default: return 3'b100;
        endcase
    endfunction

    function automatic logic [2:0] tab_lo(int s);
        case (s)
            0, 5:    return 3'b010;
            1, 2:    return 3'b100;
            default: return 3'b001;
        endcase
    endfunction

    function automatic logic [2:0] want_hs_n();
        if (supply_low || !brake_n) return 3'b111;
        return ~tab_hi(exp_step);
    endfunction

    function automatic logic [2:0] want_ls();
        if (supply_low) return 3'b000;
        if (!brake_n) return 3'b111;
        return pwm_gate ? tab_lo(exp_step) : 3'b000;
    endfunction

    task automatic check(string req, logic [2:0] act, logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic wait_cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    // One commutation pulse; the model steps with the direction now applied.
    task automatic comm_pulse();
        comm_clk = 1'b1;
        wait_cycles(4);
        comm_clk = 1'b0;
        wait_cycles(4);
        exp_step = dir_rev ? (exp_step + 5) % 6 : (exp_step + 1) % 6;
    endtask

    task automatic check_steady(string req);
        check({req, " hs_n"}, hs_n, want_hs_n());
        check({req, " ls"}, ls, want_ls());
        check({req, " fault_n"}, {2'b00, fault_n}, {2'b00, !supply_low});
    endtask

    // Monitor for R10 overlap and R11 off-gap on every leg.
    int off_run [3];
    int last_on [3];
    logic [2:0] prev_hi = 3'b000;
    logic [2:0] prev_lo = 3'b000;

    always @(negedge clk) begin
        if (rst_n) begin
            for (int p = 0; p < 3; p++) begin
                if (!hs_n[p] && ls[p]) overlaps++;
                if (!hs_n[p] && !prev_hi[p]) begin
                    if (last_on[p] == 2) begin
                        checks++;
                        if (off_run[p] < DEAD + 1) begin
                            errors++;
                            $display("FAIL R11 leg %0d hi gap actual=%0d expected>=%0d",
                                     p, off_run[p], DEAD + 1);
                        end
                    end
                    last_on[p] = 1;
                end
                if (ls[p] && !prev_lo[p]) begin
                    if (last_on[p] == 1) begin
                        checks++;
                        if (off_run[p] < DEAD + 1) begin
                            errors++;
                            $display("FAIL R11 leg %0d lo gap actual=%0d expected>=%0d",
                                     p, off_run[p], DEAD + 1);
                        end
                    end
                    last_on[p] = 2;
                end
                if (!hs_n[p] || ls[p]) off_run[p] = 0;
                else off_run[p] = off_run[p] + 1;
            end
            prev_hi = ~hs_n;
            prev_lo = ls;
        end
    end

    initial begin
        for (int p = 0; p < 3; p++) begin
            off_run[p] = 0;
            last_on[p] = 0;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd20240611);

        // R1: reset state
        wait_cycles(3);
        check("R1 reset hs_n", hs_n, 3'b111);
        check("R1 reset ls", ls, 3'b000);
        check("R1 reset fault_n", {2'b00, fault_n}, 3'b000);
        rst_n = 1'b1;
        wait_cycles(12);
        check_steady("R1 step0 after release");
        check_steady("R2 step0 table");

        // R3: forward stepping through the whole table
        dir_rev = 1'b0;
        for (int i = 0; i < 6; i++) begin
            comm_pulse();
            wait_cycles(12);
            check_steady("R3 forward");
        end

        // R3: no step without a commutation edge
        wait_cycles(40);
        check_steady("R3 hold");

        // R4: reverse applied on the next edge
        dir_rev = 1'b1;
        for (int i = 0; i < 4; i++) begin
            comm_pulse();
            wait_cycles(12);
            check_steady("R4 reverse");
        end

        // R5: PWM chop removes low sides only
        pwm_gate = 1'b0;
        wait_cycles(4);
        check_steady("R5 pwm low");
        pwm_gate = 1'b1;
        wait_cycles(12);
        check_steady("R5 pwm restore");

        // R8: brake ignores PWM
        brake_n = 1'b0;
        pwm_gate = 1'b0;
        wait_cycles(12);
        check_steady("R8 brake");
        brake_n = 1'b1;
        pwm_gate = 1'b1;
        wait_cycles(12);

        // R9: undervoltage while the step keeps following comm_clk
        supply_low = 1'b1;
        wait_cycles(3);
        check_steady("R9 uv off");
        dir_rev = 1'b0;
        comm_pulse();
        wait_cycles(4);
        supply_low = 1'b0;
        wait_cycles(12);
        check_steady("R9 uv recover stepped");

        // Random mix of direction and overrides between steps
        for (int i = 0; i < 80; i++) begin
            dir_rev    = ($urandom % 2) != 0;
            pwm_gate   = ($urandom % 4) != 0;
            brake_n    = ($urandom % 5) != 0;
            supply_low = ($urandom % 8) == 0;
            comm_pulse();
            wait_cycles(14);
            check_steady("R2 R4 R8 R9 random");
        end

        // R6: single trip blanks low sides for OFF cycles
        dir_rev = 1'b0;
        pwm_gate = 1'b1;
        brake_n = 1'b1;
        supply_low = 1'b0;
        wait_cycles(14);
        check_steady("R6 pre-trip");
        ilim_trip = 1'b1;
        @(negedge clk);
        ilim_trip = 1'b0;
        wait_cycles(OFF - 3);
        check("R6 trip ls", ls, 3'b000);
        check("R6 trip hs_n", hs_n, ~tab_hi(exp_step));
        wait_cycles(6);
        check("R6 after trip ls", ls, tab_lo(exp_step));

        // R7: second trip inside the window restarts it
        ilim_trip = 1'b1;
        @(negedge clk);
        ilim_trip = 1'b0;
        wait_cycles(9);
        ilim_trip = 1'b1;
        @(negedge clk);
        ilim_trip = 1'b0;
        wait_cycles(OFF - 3);
        check("R7 retrigger ls", ls, 3'b000);
        wait_cycles(6);
        check("R7 retrigger end ls", ls, tab_lo(exp_step));

        // R8: brake with running off-time holds low sides off
        brake_n = 1'b0;
        ilim_trip = 1'b1;
        @(negedge clk);
        ilim_trip = 1'b0;
        wait_cycles(4);
        check("R8 brake trip ls", ls, 3'b000);
        check("R8 brake trip hs_n", hs_n, 3'b111);
        wait_cycles(OFF + 4);
        check("R8 brake after trip ls", ls, 3'b111);
        brake_n = 1'b1;
        wait_cycles(12);

        // R10: overlap tally
        check("R10 overlap count", overlaps[2:0], 3'b000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule